// File: doc/BRIEF.md
# Serial Byte-Stream Memory Slave

The block is a mode-0 SPI target that gives an SPI master access to a 512-byte array kept in flip-flops. Each transfer is framed by an active-low chip select. It starts with a command byte. For the data commands, that byte also carries the top address bit, and a second byte supplies the low eight address bits. From then on, bytes stream in either direction for as long as the master keeps clocking. The internal address pointer advances by one after each byte and wraps from the top of the array back to zero. There is no page buffer: each received byte is committed to the array on its eighth clock.

Three things gate writes. A write-enable latch must first be set by a separate command. That latch drops again when a write frame closes. A protected address range, chosen by a parameter, never accepts data.

A hold input pauses a transfer in mid-byte without losing its place. While the pause lasts, serial clock edges and chip-select changes leave the shift state alone. SCK, CS, SI and HOLD are sampled in the `clk_i` domain, so the serial clock must be several times slower than `clk_i`.

Top module: `spi_mem_slave`

## Requirements
- R1: Command byte values, with bit 3 masked off, are 0x06 (set write-enable latch), 0x02 (write) and 0x03 (read). For write and read, bit 3 of the command byte is address bit 8, and the next byte gives address bits 7..0, so 0x0A and 0x0B reach 0x100..0x1FF. Any other command byte makes the rest of the frame ignored.
- R2: A write frame issued while the write-enable latch is clear leaves every array byte unchanged.
- R3: After the address, each complete group of 8 SI bits is written to the array at the current address on its 8th rising SCK edge. The number of bytes in one frame is unlimited.
- R4: The address pointer advances by one after every data byte, in both reads and writes, and goes from 0x1FF to 0x000.
- R5: Data moves MSB first in both directions. During the read data phase, SI has no effect on the returned bytes.
- R6: Chip select going high ends the frame. Bits of a data byte received before that edge, fewer than 8, are discarded and never written.
- R7: The write-enable latch clears when chip select rises on a frame that carried a write command. Each write frame needs a fresh 0x06 frame.
- R8: With PROT_MODE=1 (the default), addresses 0x180..0x1FF never accept data. The modes are 0 none, 1 top quarter, 2 top half, 3 whole array. A data byte aimed at a locked address is dropped, but the pointer still advances.
- R9: HOLD low sampled while SCK is low pauses the transfer, and HOLD high sampled while SCK is low resumes it. SCK edges during the pause change nothing, and the interrupted byte completes correctly after resume.
- R10: so_oe_o is low whenever chip select is high or a hold is in effect. In the read data phase it is high, and so_o presents the next bit after each falling SCK edge.
- R11: After reset, the latch is clear, every array byte is 0x00 and so_oe_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | Serial clock from the master, mode 0 |
| cs_ni | input | 1 | Chip select, active low |
| si_i | input | 1 | Serial data into the block |
| hold_ni | input | 1 | Pause request, active low |
| so_o | output | 1 | Serial data out of the block |
| so_oe_o | output | 1 | Output enable for so_o; low means high impedance |

## Verification
The bench builds the block with its defaults: AW=9 and PROT_MODE=1. With these values, a write burst that starts at 0x1FE crosses the locked top quarter and then wraps into unlocked low addresses. That single burst shows the dropped bytes, the continuing pointer and the wrap together. The 0x0A/0x0B command forms reach the upper half, and addresses below 0x180 there stay writable, so address bit 8 and the locked range can be told apart.

// File: rtl/spi_mem_pkg.sv
package spi_mem_pkg;
  typedef enum logic [2:0] {
    ST_CMD,
    ST_ADR,
    ST_WDAT,
    ST_RDAT,
    ST_SKIP
  } mem_st_e;

  localparam logic [7:0] CMD_WEN = 8'h06;
  localparam logic [7:0] CMD_WR  = 8'h02;
  localparam logic [7:0] CMD_RD  = 8'h03;
  localparam int         HI_BIT  = 3;  // command bit carrying the top address bit
endpackage

// File: rtl/spi_mem_front.sv
module spi_mem_front (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic si_i,
  input  logic hold_ni,
  output logic rise_o,
  output logic fall_o,
  output logic si_o,
  output logic act_o,
  output logic end_o,
  output logic hold_o,
  output logic cs_o
);
  logic sck_d, sck_p, cs_d, si_d, hold_d, hold_q, act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d  <= 1'b0;
      sck_p  <= 1'b0;
      cs_d   <= 1'b1;
      si_d   <= 1'b0;
      hold_d <= 1'b1;
      hold_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      sck_d  <= sck_i;
      sck_p  <= sck_d;
      cs_d   <= cs_ni;
      si_d   <= si_i;
      hold_d <= hold_ni;
      if (!sck_d) hold_q <= !hold_d;   // pause changes only with SCK low
      if (!hold_q) act_q <= !cs_d;     // framing frozen during a pause
    end
  end

  assign rise_o = act_q & !hold_q & !cs_d & sck_d & !sck_p;
  assign fall_o = act_q & !hold_q & !cs_d & !sck_d & sck_p;
  assign end_o  = act_q & !hold_q & cs_d;
  assign si_o   = si_d;
  assign act_o  = act_q;
  assign hold_o = hold_q;
  assign cs_o   = cs_d;
endmodule

// File: rtl/spi_mem_shift.sv
module spi_mem_shift #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         rise_i,
  input  logic         si_i,
  output logic [W-1:0] byte_o,
  output logic         done_o
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-2:0]  sr_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (rise_i) begin
      sr_q  <= {sr_q[W-3:0], si_i};
      cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  assign byte_o = {sr_q, si_i};
  assign done_o = rise_i & (cnt_q == LAST);
endmodule

// File: rtl/spi_mem_array.sv
module spi_mem_array #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/spi_mem_ctrl.sv
module spi_mem_ctrl
  import spi_mem_pkg::*;
#(
  parameter int AW        = 9,
  parameter int PROT_MODE = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          act_i,
  input  logic          end_i,
  input  logic          done_i,
  input  logic [7:0]    byte_i,
  input  logic          fall_i,
  input  logic [7:0]    rdata_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [7:0]    wdata_o,
  output logic [AW-1:0] raddr_o,
  output logic          so_o,
  output logic          rd_phase_o,
  output logic          wel_o,
  output logic          wr_cmd_o,
  output logic [AW-1:0] addr_o
);
  localparam int DEPTH   = 1 << AW;
  localparam int PROT_LO = (PROT_MODE == 0) ? DEPTH : DEPTH - (DEPTH >> (3 - PROT_MODE));
  localparam logic [AW:0] LO_V = PROT_LO[AW:0];
  localparam logic [7:0]  HI_MASK = ~(8'h01 << HI_BIT);

  mem_st_e       st_q;
  logic [AW-1:0] addr_q;
  logic          wr_q, rd_q, wel_q, so_q;
  logic [7:0]    osr_q;
  logic [7:0]    cmd_base;
  logic          unlocked;

  assign cmd_base = byte_i & HI_MASK;
  assign unlocked = {1'b0, addr_q} < LO_V;
  assign raddr_o  = (st_q == ST_ADR) ? {addr_q[AW-1:8], byte_i} : addr_q;
  assign we_o     = done_i & (st_q == ST_WDAT) & wel_q & unlocked;
  assign waddr_o  = addr_q;
  assign wdata_o  = byte_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q <= 1'b0;
    end else if (end_i && wr_q) begin
      wel_q <= 1'b0;
    end else if (done_i && st_q == ST_CMD && byte_i == CMD_WEN) begin
      wel_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_CMD;
      addr_q <= '0;
      wr_q   <= 1'b0;
      rd_q   <= 1'b0;
      osr_q  <= '0;
      so_q   <= 1'b0;
    end else if (!act_i) begin
      st_q <= ST_CMD;
      wr_q <= 1'b0;
      rd_q <= 1'b0;
    end else begin
      if (done_i) begin
        case (st_q)
          ST_CMD: begin
            if (cmd_base == CMD_WR) begin
              wr_q         <= 1'b1;
              addr_q[AW-1] <= byte_i[HI_BIT];
              st_q         <= ST_ADR;
            end else if (cmd_base == CMD_RD) begin
              rd_q         <= 1'b1;
              addr_q[AW-1] <= byte_i[HI_BIT];
              st_q         <= ST_ADR;
            end else begin
              st_q <= ST_SKIP;
            end
          end
          ST_ADR: begin
            if (rd_q) begin
              osr_q  <= rdata_i;
              addr_q <= raddr_o + 1'b1;
              st_q   <= ST_RDAT;
            end else begin
              addr_q <= raddr_o;
              st_q   <= ST_WDAT;
            end
          end
          ST_WDAT: addr_q <= addr_q + 1'b1;
          ST_RDAT: begin
            osr_q  <= rdata_i;
            addr_q <= addr_q + 1'b1;
          end
          default: st_q <= ST_SKIP;
        endcase
      end
      if (fall_i && st_q == ST_RDAT) begin
        so_q  <= osr_q[7];
        osr_q <= {osr_q[6:0], 1'b0};
      end
    end
  end

  assign so_o       = so_q;
  assign rd_phase_o = (st_q == ST_RDAT);
  assign wel_o      = wel_q;
  assign wr_cmd_o   = wr_q;
  assign addr_o     = addr_q;
endmodule

// File: rtl/spi_mem_slave.sv
module spi_mem_slave #(
  parameter int AW        = 9,
  parameter int PROT_MODE = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic cs_ni,
  input  logic si_i,
  input  logic hold_ni,
  output logic so_o,
  output logic so_oe_o
);
  logic          rise, fall, si_s, act, frame_end, hold_act, cs_s;
  logic [7:0]    rx_byte;
  logic          rx_done;
  logic          mem_we;
  logic [AW-1:0] mem_waddr, mem_raddr, cur_addr;
  logic [7:0]    mem_wdata, mem_rdata;
  logic          rd_phase, wel, wr_cmd, so_bit;

  spi_mem_front u_front (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sck_i  (sck_i),
    .cs_ni  (cs_ni),
    .si_i   (si_i),
    .hold_ni(hold_ni),
    .rise_o (rise),
    .fall_o (fall),
    .si_o   (si_s),
    .act_o  (act),
    .end_o  (frame_end),
    .hold_o (hold_act),
    .cs_o   (cs_s)
  );

  spi_mem_shift #(.W(8)) u_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (!act),
    .rise_i(rise),
    .si_i  (si_s),
    .byte_o(rx_byte),
    .done_o(rx_done)
  );

  spi_mem_ctrl #(.AW(AW), .PROT_MODE(PROT_MODE)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .act_i     (act),
    .end_i     (frame_end),
    .done_i    (rx_done),
    .byte_i    (rx_byte),
    .fall_i    (fall),
    .rdata_i   (mem_rdata),
    .we_o      (mem_we),
    .waddr_o   (mem_waddr),
    .wdata_o   (mem_wdata),
    .raddr_o   (mem_raddr),
    .so_o      (so_bit),
    .rd_phase_o(rd_phase),
    .wel_o     (wel),
    .wr_cmd_o  (wr_cmd),
    .addr_o    (cur_addr)
  );

  spi_mem_array #(.AW(AW), .DW(8)) u_array (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (mem_we),
    .waddr_i(mem_waddr),
    .wdata_i(mem_wdata),
    .raddr_i(mem_raddr),
    .rdata_o(mem_rdata)
  );

  assign so_o    = so_bit;
  assign so_oe_o = !cs_s & act & !hold_act & rd_phase;
endmodule

// File: rtl/spi_mem_slave_chk.sv
module spi_mem_slave_chk #(
  parameter int AW        = 9,
  parameter int PROT_MODE = 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_ni,
  input logic          sck_i,
  input logic          hold_ni,
  input logic          so_oe_o,
  input logic          mem_we,
  input logic [AW-1:0] mem_waddr,
  input logic          wel,
  input logic          wr_cmd,
  input logic          act,
  input logic          hold_act,
  input logic          frame_end,
  input logic [AW-1:0] cur_addr
);
  function automatic int first_locked();
    case (PROT_MODE)
      1:       return 3 * (1 << AW) / 4;
      2:       return (1 << AW) / 2;
      3:       return 0;
      default: return 1 << AW;
    endcase
  endfunction

  AST_SO_CS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cs_ni) |-> !so_oe_o) else $error("so driven with cs high");  // R10

  AST_SO_HOLD_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!hold_ni, 2) && $past(!sck_i, 2)) |-> !so_oe_o) else $error("so driven in hold");  // R10

  AST_WE_NEEDS_WEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> wel) else $error("array write without latch");  // R2

  AST_WE_UNLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> (int'(mem_waddr) < first_locked())) else $error("write to locked range");  // R8

  AST_WEL_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(act) && $past(wr_cmd)) |-> !wel) else $error("latch survived write frame");  // R7

  AST_FRAME_END_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end |=> !act) else $error("frame end did not close frame");  // R6

  AST_HOLD_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_act && $past(hold_act)) |-> $stable(cur_addr)) else $error("pointer moved in hold");  // R9
endmodule

bind spi_mem_slave spi_mem_slave_chk #(.AW(AW), .PROT_MODE(PROT_MODE)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cs_ni    (cs_ni),
  .sck_i    (sck_i),
  .hold_ni  (hold_ni),
  .so_oe_o  (so_oe_o),
  .mem_we   (mem_we),
  .mem_waddr(mem_waddr),
  .wel      (wel),
  .wr_cmd   (wr_cmd),
  .act      (act),
  .hold_act (hold_act),
  .frame_end(frame_end),
  .cur_addr (cur_addr)
);

// File: tb/spi_mem_slave_bench.sv
`timescale 1ns/1ps
module spi_mem_slave_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, hold_n = 1'b1;
  logic so, so_oe;

  int checks = 0;
  int errors = 0;
  logic [7:0] ref_mem [512];
  bit ref_wel = 1'b0;
  int cs_high_run = 0;

  always #2 clk = ~clk;  // 250 MHz

  spi_mem_slave u_spi_mem_slave (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .cs_ni(cs_n),
    .si_i(si), .hold_ni(hold_n), .so_o(so), .so_oe_o(so_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock: output enable must be off once chip select has been high for two samples (R10)
  always @(negedge clk) begin
    if (rst_n) begin
      if (cs_high_run >= 2) check(so_oe == 1'b0, "R10 oe with cs high", so_oe, 0);
      cs_high_run = cs_n ? cs_high_run + 1 : 0;
    end
  end

  function automatic bit locked(input int a);
    return a >= 'h180;  // R8 default mode: top quarter
  endfunction

  task automatic bit_x(input logic b, output logic so_v, output logic oe_v);
    @(negedge clk) si = b;
    repeat (3) @(negedge clk);
    so_v = so; oe_v = so_oe;
    sck = 1'b1;
    repeat (4) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic pause(output logic oe_in_hold);
    @(negedge clk) hold_n = 1'b0;
    repeat (4) @(negedge clk);
    oe_in_hold = so_oe;
    for (int k = 0; k < 3; k++) begin
      sck = 1'b1; si = ~si;
      repeat (3) @(negedge clk);
      sck = 1'b0;
      repeat (3) @(negedge clk);
    end
    hold_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // hold_at: bit index (0 = first) before which a pause is inserted; 8 = none
  task automatic byte_x(input logic [7:0] tx, input int hold_at,
                        output logic [7:0] rx, output logic oe_all, output logic oe_hold);
    logic s, o;
    oe_all = 1'b1; oe_hold = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (i == hold_at) pause(oe_hold);
      bit_x(tx[7-i], s, o);
      rx[7-i] = s;
      oe_all &= o;
    end
  endtask

  task automatic cs_on();
    @(negedge clk) cs_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cs_off();
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b);
    logic [7:0] r; logic x, y;
    byte_x(b, 8, r, x, y);
  endtask

  task automatic do_wren();
    cs_on(); send(8'h06); cs_off();
    ref_wel = 1'b1;
  endtask

  task automatic do_write(input int a, input logic [7:0] d[$]);
    int p = a;
    cs_on();
    send(8'h02 | (8'(a >> 8) << 3));
    send(8'(a));
    foreach (d[k]) begin
      send(d[k]);
      if (ref_wel && !locked(p)) ref_mem[p] = d[k];
      p = (p + 1) % 512;
    end
    cs_off();
    ref_wel = 1'b0;
  endtask

  task automatic do_read(input int a, input int n, input string req);
    int p = a;
    logic [7:0] r; logic oe, h;
    cs_on();
    send(8'h03 | (8'(a >> 8) << 3));
    send(8'(a));
    for (int k = 0; k < n; k++) begin
      byte_x(8'($urandom), 8, r, oe, h);  // random SI during read (R5)
      check(r === ref_mem[p] && oe, req, {oe, r}, {1'b1, ref_mem[p]});
      p = (p + 1) % 512;
    end
    cs_off();
  endtask

  initial begin
    fork
      begin : main
        logic [7:0] r; logic oe, h, s, o;
        for (int i = 0; i < 512; i++) ref_mem[i] = 8'h00;
        repeat (5) @(negedge clk);
        check(so_oe == 1'b0, "R11 oe in reset", so_oe, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(so_oe == 1'b0, "R11 oe after reset", so_oe, 0);

        // R2: write without latch, then read zeros (also R11 array clear)
        do_write('h010, '{8'hAA, 8'h55});
        do_read('h010, 2, "R2 no-latch write");

        // R3 R4 R8: burst from 0x1FE, locked top quarter, wrap into 0x000
        do_wren();
        do_write('h1FE, '{8'hA1, 8'hB2, 8'hC3, 8'hD4});
        do_read('h1FE, 4, "R4 R8 wrap and lock");

        // R7: latch cleared by previous write frame
        do_write('h020, '{8'h77});
        do_read('h020, 1, "R7 latch cleared");

        // R1: upper half via 0x0A/0x0B, distinct from lower half
        do_wren();
        do_write('h105, '{8'h3E, 8'h4F});
        do_wren();
        do_write('h005, '{8'h61});
        do_read('h105, 2, "R1 upper half");
        do_read('h005, 1, "R1 lower half");

        // R3: long burst, unlimited length
        do_wren();
        do_write('h0F0, '{8'h01, 8'h12, 8'h23, 8'h34, 8'h45, 8'h56, 8'h67, 8'h78,
                          8'h89, 8'h9A, 8'hAB, 8'hBC, 8'hCD, 8'hDE, 8'hEF, 8'hF0,
                          8'h0F, 8'h1E, 8'h2D, 8'h3C});
        do_read('h0F0, 20, "R3 R5 long burst");

        // R6: partial byte discarded
        do_wren();
        cs_on();
        send(8'h02); send(8'h30); send(8'h11);
        for (int i = 0; i < 5; i++) bit_x(1'b1, s, o);
        cs_off();
        ref_mem['h030] = 8'h11; ref_wel = 1'b0;
        do_read('h030, 2, "R6 partial byte");

        // R9: pause inside a written byte
        do_wren();
        cs_on();
        send(8'h02); send(8'h40);
        byte_x(8'h5A, 3, r, oe, h);
        send(8'h3C);
        cs_off();
        ref_mem['h040] = 8'h5A; ref_mem['h041] = 8'h3C; ref_wel = 1'b0;
        do_read('h040, 2, "R9 hold in write");

        // R9 R10: pause inside a read byte, oe off during pause
        cs_on();
        send(8'h03); send(8'h40);
        byte_x(8'h00, 4, r, oe, h);
        check(h == 1'b0, "R10 oe off in hold", h, 0);
        check(r === 8'h5A, "R9 hold in read", r, 8'h5A);
        byte_x(8'hFF, 8, r, oe, h);
        check(r === 8'h3C && oe, "R9 resume read", r, 8'h3C);
        cs_off();

        // R1: unknown command ignores the frame
        do_wren();
        cs_on(); send(8'h05); send(8'h50); send(8'h99); cs_off();
        ref_wel = 1'b1;
        do_write('h050, '{8'h42});
        do_read('h050, 1, "R1 unknown command");
      end
      begin : watchdog
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule